// File: doc/BRIEF.md
# Serial Control Register Port

This block lets a host controller reach a small bank of eight byte-wide configuration registers through a three-wire serial link. The link has an active-low select, a shift clock and a serial data input, plus a serial data output that the pad ring tri-states. The block does not run on the shift clock. It samples all three link inputs in its own system clock domain, passes them through a synchronizer and finds the shift-clock edges there. The system clock therefore has to run several times faster than the shift clock. At the 100 MHz system clock used here, the shift clock can reach 10 MHz.

A frame starts with a direction flag, then three address bits, then eight data bits. Every bit goes most significant bit first and is captured on a rising shift-clock edge while select is low. A write frame updates its register only once the last data bit has arrived. A read frame drives the complement of the selected register onto the output, one bit per falling shift-clock edge. The top register has no storage of its own: it mirrors a status input bus and cannot be written.

An active-low hardware reset loads every register with its default value. The power-down output is the OR of that reset and one configuration bit. Setting the configuration bit does not disturb any stored value. The register contents leave the block on a flat bus for the logic that uses them.

Top module: `serial_reg_port`

## Requirements
- R1: A frame is sampled on rising `sck` edges while `sel_n` is low, in this order: the direction flag (1 = read, 0 = write), then address bits 2, 1, 0, then data bits 7 down to 0.
- R2: The bank holds eight 8-bit registers, at addresses 0 to 7. Register k appears on `cfg_out[8k+7:8k]`, and a value written to any of addresses 0 to 6 reads back unchanged.
- R3: `sdo_oe` is low whenever no read is in progress, and throughout every write frame. In a read frame it goes high at the falling edge that follows the rising edge which captured address bit 0. It goes low again once `sel_n` returns high.
- R4: Read data on `sdo` is the bitwise complement of the addressed register, sent MSB first. Each bit is presented on a falling `sck` edge, from the edge after address bit 0 through the eighth one.
- R5: A write takes effect only after all eight data bits have been captured. If `sel_n` rises earlier, every register keeps its value.
- R6: Address 7 is read-only. It follows `status_in` on every system clock, and a write frame to it changes nothing.
- R7: While `rst_n` is low, register 2 holds 0x33 and every other writable register holds 0x00.
- R8: `pwr_down` is high when `rst_n` is low or when bit 5 of register 0 is set. Setting that bit leaves all register contents as they were.
- R9: Rising `sck` edges after the twelfth edge of a frame are ignored until `sel_n` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the serial link |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sck | input | 1 | Serial shift clock from the host, idle low |
| sdi | input | 1 | Serial data from the host |
| status_in | input | 8 | Status bits mirrored into read-only address 7 |
| sdo | output | 1 | Serial read data, inverted |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| cfg_out | output | 64 | All eight registers, register k at bits 8k+7..8k |
| pwr_down | output | 1 | Power-down request: hardware reset OR register 0 bit 5 |

## Verification
Four properties are checked on every cycle. The output enable must drop within one cycle of the synchronized select going high. The enable may be high only inside a read frame. Writable registers may change only in the cycle after a write strobe. The status register must follow its input with a one-cycle delay. The bench's scenarios cover what those local checks cannot see. These are the bit order and inversion of read data, the count of eight data bits before a write commits, the handling of aborted frames and surplus shift-clock edges, the reset image, and the retention of register contents under software power-down.

// File: rtl/srp_pkg.sv
package srp_pkg;
    localparam int REG_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int NUM_REGS   = 1 << ADDR_W;
    localparam int FRAME_BITS = 1 + ADDR_W + REG_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int STAT_IDX   = NUM_REGS - 1;
    localparam int GAIN_IDX   = 2;
    localparam logic [REG_W-1:0] GAIN_RST = 8'h33;

    // Frame engine state
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;      // rising edges seen in this frame
        logic              is_rd;    // direction flag of this frame
        logic [ADDR_W-1:0] addr;     // captured address
        logic [REG_W-1:0]  rx;       // captured write data
        logic [REG_W-1:0]  tx;       // remaining read bits
        logic              oe;       // output enable
        logic              dout;     // output bit
        logic              wr_stb;   // one-cycle commit strobe
        logic              sck_prev; // previous synchronized sck
    } frame_t;

    function automatic logic [REG_W-1:0] reset_value(int unsigned idx);
        return (idx == GAIN_IDX) ? GAIN_RST : '0;
    endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/srp_frame.sv
module srp_frame
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sck,
    input  logic              din,
    input  logic [REG_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_stb,
    output logic [REG_W-1:0]  wr_data,
    output logic              dout,
    output logic              dout_oe,
    output logic              is_rd
);
    localparam logic [CNT_W-1:0] CNT_ADDR_END = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);

    frame_t f_d, f_q;
    logic   rise, fall;

    always_comb begin
        f_d          = f_q;
        f_d.wr_stb   = 1'b0;
        f_d.sck_prev = sck;
        rise = sck & ~f_q.sck_prev;
        fall = ~sck & f_q.sck_prev;

        if (sel_n) begin
            f_d.cnt   = '0;
            f_d.is_rd = 1'b0;
            f_d.oe    = 1'b0;
        end else begin
            // capture on rising edges; surplus edges are ignored
            if (rise && f_q.cnt < CNT_FULL) begin
                f_d.cnt = f_q.cnt + 1'b1;
                if (f_q.cnt == '0)
                    f_d.is_rd = din;
                else if (f_q.cnt < CNT_ADDR_END)
                    f_d.addr = {f_q.addr[ADDR_W-2:0], din};
                else
                    f_d.rx = {f_q.rx[REG_W-2:0], din};
                if (f_q.cnt == CNT_LAST && !f_q.is_rd)
                    f_d.wr_stb = 1'b1;
            end
            // launch read bits on falling edges
            if (fall && f_q.is_rd) begin
                if (f_q.cnt == CNT_ADDR_END) begin
                    f_d.oe   = 1'b1;
                    f_d.dout = ~rd_data[REG_W-1];
                    f_d.tx   = {rd_data[REG_W-2:0], 1'b0};
                end else if (f_q.cnt > CNT_ADDR_END && f_q.cnt < CNT_FULL) begin
                    f_d.dout = ~f_q.tx[REG_W-1];
                    f_d.tx   = {f_q.tx[REG_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign addr    = f_q.addr;
    assign wr_stb  = f_q.wr_stb;
    assign wr_data = f_q.rx;
    assign dout    = f_q.dout;
    assign dout_oe = f_q.oe;
    assign is_rd   = f_q.is_rd;
endmodule

// File: rtl/srp_bank.sv
module srp_bank
    import srp_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_stb,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [REG_W-1:0]          stat_in,
    output logic [REG_W-1:0]          rd_data,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    logic [REG_W-1:0] regs_d [NUM_REGS];
    logic [REG_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i == STAT_IDX)
                regs_d[i] = stat_in;
            else if (wr_stb && addr == ADDR_W'(i))
                regs_d[i] = wr_data;
            else
                regs_d[i] = regs_q[i];
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= reset_value(g);
            else        regs_q[g] <= regs_d[g];
        end
        assign regs_flat[g*REG_W +: REG_W] = regs_q[g];
    end

    assign rd_data = regs_q[addr];
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PDN_REG     = 0,
    parameter int PDN_BIT     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_n,
    input  logic                      sck,
    input  logic                      sdi,
    input  logic [REG_W-1:0]          status_in,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic [NUM_REGS*REG_W-1:0] cfg_out,
    output logic                      pwr_down
);
    logic              sel_s, sck_s, sdi_s;
    logic [ADDR_W-1:0] frm_addr;
    logic              wr_stb, frm_is_rd;
    logic [REG_W-1:0]  wr_data, rd_data;

    srp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sel_n, sck, sdi}), .q({sel_s, sck_s, sdi_s})
    );

    srp_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sel_n(sel_s), .sck(sck_s), .din(sdi_s),
        .rd_data(rd_data), .addr(frm_addr),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .dout(sdo), .dout_oe(sdo_oe), .is_rd(frm_is_rd)
    );

    srp_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(wr_stb), .addr(frm_addr), .wr_data(wr_data),
        .stat_in(status_in), .rd_data(rd_data), .regs_flat(cfg_out)
    );

    assign pwr_down = ~rst_n | cfg_out[PDN_REG*REG_W + PDN_BIT];
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk
    import srp_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      sel_s,
    input logic                      sdo_oe,
    input logic                      frm_is_rd,
    input logic                      wr_stb,
    input logic [REG_W-1:0]          status_in,
    input logic [NUM_REGS*REG_W-1:0] cfg_out
);
    localparam int RW_BITS = (NUM_REGS - 1) * REG_W;

    // R3: driver released one cycle after the synchronized select rises
    a_r3_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !sdo_oe);

    // R3: output enabled only inside a read frame
    a_r3_oe_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> frm_is_rd);

    // R5: writable registers move only after a commit strobe
    a_r5_change_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_out[RW_BITS-1:0]));

    // R6: read-only address follows the status bus
    a_r6_status_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cfg_out[RW_BITS +: REG_W] == $past(status_in)));
endmodule

bind serial_reg_port serial_reg_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sdo_oe(sdo_oe),
    .frm_is_rd(frm_is_rd), .wr_stb(wr_stb),
    .status_in(status_in), .cfg_out(cfg_out)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
    logic        clk = 1'b0, rst_n = 1'b0, sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic        sdo, sdo_oe, pwr_down;
    logic [63:0] cfg_out;

    localparam logic [63:0] RESET_IMAGE = 64'h0000_0000_0033_0000;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] obs_q[$];

    serial_reg_port u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
        .status_in(status_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_out(cfg_out), .pwr_down(pwr_down)
    );

    always #5 clk = ~clk;

    task automatic check(bit ok, string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // one frame; nbits rising edges; returns read byte and enable verdict
    task automatic frame(bit rd, logic [2:0] a, logic [7:0] d, int nbits,
                         output logic [7:0] got, output bit oe_ok);
        logic [11:0] bits;
        bits  = {rd, a, d};
        got   = 8'h00;
        oe_ok = 1'b1;
        sel_n = 1'b0;
        #100;
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 12) ? bits[11-i] : 1'b1;
            #50 sck = 1'b1;
            #100 sck = 1'b0;
            #90;
            if (sdo_oe !== (rd && i >= 3)) oe_ok = 1'b0;
            if (rd && i >= 3 && i <= 10) got[10-i] = ~sdo;
            #10;
        end
        #100 sel_n = 1'b1;
        #200;
        if (sdo_oe !== 1'b0) oe_ok = 1'b0;
    endtask

    task automatic write_reg(logic [2:0] a, logic [7:0] d, int nbits);
        logic [7:0] g;
        bit ok;
        frame(1'b0, a, d, nbits, g, ok);
        check(ok, "R3 (write frame enable)", {63'b0, sdo_oe}, 64'h0);
    endtask

    task automatic read_reg(logic [2:0] a, logic [7:0] exp, string req);
        logic [7:0] g;
        bit ok;
        exp_q.push_back('{exp, req});
        frame(1'b1, a, 8'h00, 12, g, ok);
        obs_q.push_back(g);
        check(ok, "R3 (read frame enable)", {63'b0, sdo_oe}, 64'h0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (obs_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] o;
                exp_t e;
                o = obs_q.pop_front();
                e = exp_q.pop_front();
                check(o == e.val, e.req, {56'b0, o}, {56'b0, e.val});
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    logic [7:0] wvals [7];

    initial begin
        wvals = '{8'h5A, 8'hA5, 8'hC7, 8'h0F, 8'hF0, 8'h81, 8'h3C};
        #100;
        check(cfg_out == RESET_IMAGE, "R7 (during reset)", cfg_out, RESET_IMAGE);
        check(pwr_down == 1'b1, "R8 (reset forces power-down)", {63'b0, pwr_down}, 64'h1);
        rst_n = 1'b1;
        #100;
        check(cfg_out == RESET_IMAGE, "R7 (after release)", cfg_out, RESET_IMAGE);
        check(pwr_down == 1'b0, "R8 (power-up)", {63'b0, pwr_down}, 64'h0);
        check(sdo_oe == 1'b0, "R3 (idle)", {63'b0, sdo_oe}, 64'h0);

        // R1 / R2: write every writable register
        for (int k = 0; k < 7; k++) begin
            write_reg(3'(k), wvals[k], 12);
            check(cfg_out[k*8 +: 8] == wvals[k], "R1 (write lands at address)",
                  {56'b0, cfg_out[k*8 +: 8]}, {56'b0, wvals[k]});
        end
        // R2 / R4: read back, inverted MSB first on the wire
        read_reg(3'd0, 8'h5A, "R4 (read reg0)");
        for (int k = 1; k < 7; k++) read_reg(3'(k), wvals[k], "R2 (read back)");

        // R6: status register is read-only
        status_in = 8'h96;
        #50;
        read_reg(3'd7, 8'h96, "R6 (status read)");
        write_reg(3'd7, 8'h11, 12);
        check(cfg_out[63:56] == 8'h96, "R6 (write to status ignored)",
              {56'b0, cfg_out[63:56]}, 64'h96);
        read_reg(3'd7, 8'h96, "R6 (status after write attempt)");
        check(cfg_out[55:0] == {8'h3C, 8'h81, 8'hF0, 8'h0F, 8'hC7, 8'hA5, 8'h5A},
              "R6 (other registers untouched)", {8'h0, cfg_out[55:0]},
              {8'h0, 8'h3C, 8'h81, 8'hF0, 8'h0F, 8'hC7, 8'hA5, 8'h5A});

        // R5: aborted writes
        write_reg(3'd3, 8'h77, 8);
        check(cfg_out[31:24] == 8'h0F, "R5 (abort mid data)", {56'b0, cfg_out[31:24]}, 64'h0F);
        write_reg(3'd3, 8'h77, 11);
        check(cfg_out[31:24] == 8'h0F, "R5 (abort before last bit)", {56'b0, cfg_out[31:24]}, 64'h0F);

        // R9: surplus shift-clock edges
        write_reg(3'd4, 8'h12, 15);
        check(cfg_out[39:32] == 8'h12, "R9 (surplus edges ignored)", {56'b0, cfg_out[39:32]}, 64'h12);

        // R8: software power-down keeps contents
        write_reg(3'd0, 8'h7A, 12);
        check(pwr_down == 1'b1, "R8 (software power-down)", {63'b0, pwr_down}, 64'h1);
        check(cfg_out[15:8] == 8'hA5 && cfg_out[23:16] == 8'hC7, "R8 (contents kept)",
              {48'b0, cfg_out[23:8]}, 64'hC7A5);

        // R7: hardware reset restores defaults
        status_in = 8'h00;
        rst_n = 1'b0;
        #50;
        rst_n = 1'b1;
        #100;
        check(cfg_out == RESET_IMAGE, "R7 (hardware reset)", cfg_out, RESET_IMAGE);
        check(pwr_down == 1'b0, "R7 (power-down bit cleared)", {63'b0, pwr_down}, 64'h0);
        read_reg(3'd2, 8'h33, "R7 (default read)");

        #200;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule